// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the software-visible face of a simple LCD controller. A bus master writes and reads six 32-bit registers through a synchronous port. Writes land on the clock edge. Read data is a combinational function of the address.

The registers are:
- a control word that holds the enable, monochrome, interrupt-mask, panel-type and palette-load-mode fields;
- three timing words, the first two of which carry the panel width and height as value minus one in their low ten bits;
- a status word;
- a subpanel word.

An external frame sequencer sets and clears three event flags: frame done, palette done and sync error. The block merges these flags into one level interrupt. A change of the enable bit is announced to the sequencer as a one-clock pulse, together with the new enable value. Pixel fetch, DMA and display timing generation belong to other blocks.

Top module: `lcdc_regblk`

## Requirements
- R1: A write to offset 0x00 loads enable from bit 0, monochrome from bit 1, a 2-bit interrupt mask from bits 4:3, panel type (TFT) from bit 7 and a 2-bit palette-load mode from bits 21:20. These fields appear on `lcd_en_o`, `mono_o`, `tft_o` and `pal_mode_o` one clock after the write.
- R2: A read of offset 0x00 returns the five fields in their write positions, the TFT bit repeated at bit 23, and the written bits selected by mask 0x01cff300, all ORed with 0xfe000c34.
- R3: Offsets 0x04 and 0x08 keep the whole written word. Bits 9:0 of each are width minus one and height minus one, and `width_o`/`height_o` show the field plus one. A read returns the stored word, with 0x0000000f ORed in at offset 0x04 only.
- R4: Offset 0x0c keeps the whole written word and reads back with 0xfc000000 ORed in.
- R5: A read of offset 0x10 returns frame done at bit 0, sync error at bit 2 and palette done at bit 6, with all other bits zero. Bus writes to 0x10 change no flag.
- R6: Offset 0x14 stores the written word ANDed with 0xa1ffffff and reads it back.
- R7: `irq_o` is high while frame done is set with mask bit 0 (bit 3 of control) set, or palette done is set with mask bit 1 (bit 4) set, or sync error is set whatever the mask. Otherwise it is low.
- R8: A control write whose bit 0 differs from the current enable raises `en_chg_o` for exactly one clock, beginning with the clock on which `lcd_en_o` takes the new value. A control write that leaves the enable unchanged raises no pulse.
- R9: Flag index 0 is frame done, index 1 is palette done and index 2 is sync error in `flag_set_i`/`flag_clr_i`. A set or clear bit takes effect on the next clock, set wins when both are high, and a flag otherwise holds.
- R10: After reset, all fields, timing words, subpanel and flags are zero. The registers then read 0xfe000c34, 0x0000000f, 0, 0xfc000000, 0 and 0 at 0x00, 0x04, 0x08, 0x0c, 0x10 and 0x14, and `irq_o` and `en_chg_o` are low.
- R11: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| flag_set_i | input | 3 | Per-flag set requests from the frame sequencer |
| flag_clr_i | input | 3 | Per-flag clear requests from the frame sequencer |
| irq_o | output | 1 | Level interrupt |
| en_chg_o | output | 1 | One-clock pulse on a change of the enable bit |
| lcd_en_o | output | 1 | Current enable value |
| mono_o | output | 1 | Monochrome select |
| tft_o | output | 1 | Panel type select |
| pal_mode_o | output | 2 | Palette-load mode |
| width_o | output | DIM_W+1 | Panel width in pixels |
| height_o | output | DIM_W+1 | Panel height in lines |

## Verification
Some properties are checked by assertions on every clock:
- a sync error always drives the interrupt, and a clear mask with no sync error keeps it low;
- every change of the enable value coincides with the change pulse, and the pulse never appears without a change;
- a set request always lands, and an idle flag holds;
- control reads always carry their constant ones, subpanel reads never show masked bits, status reads show only the three flag bits, and unmapped reads are zero.

Other behaviour only the bench scenarios can show: the exact bit placement of each written field, the plus-one dimensions, the reset values, the set-over-clear priority on a shared cycle, and that status and unmapped writes leave every register as it was.

// File: rtl/lcdc_reg_pkg.sv
package lcdc_reg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_TIM = 3;
  localparam int unsigned NUM_FLG = 3;

  // byte offsets
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_TIM0 = 'h04;
  localparam int unsigned OFS_TIM1 = 'h08;
  localparam int unsigned OFS_TIM2 = 'h0c;
  localparam int unsigned OFS_STAT = 'h10;
  localparam int unsigned OFS_SUB  = 'h14;

  // control field positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_MONO   = 1;
  localparam int unsigned CB_MASK   = 3;
  localparam int unsigned CB_TFT    = 7;
  localparam int unsigned CB_PLM    = 20;
  localparam int unsigned CB_TFT_HI = 23;

  // flag indices and status bit positions
  localparam int unsigned FLG_FRAME = 0;
  localparam int unsigned FLG_PAL   = 1;
  localparam int unsigned FLG_SYNC  = 2;
  localparam int unsigned SB_FRAME  = 0;
  localparam int unsigned SB_SYNC   = 2;
  localparam int unsigned SB_PAL    = 6;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h01cf_f300;
  localparam logic [DATA_W-1:0] CTRL_ONES = 32'hfe00_0c34;
  localparam logic [DATA_W-1:0] TIM0_ONES = 32'h0000_000f;
  localparam logic [DATA_W-1:0] TIM2_ONES = 32'hfc00_0000;
  localparam logic [DATA_W-1:0] SUB_KEEP  = 32'ha1ff_ffff;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUB
  } reg_sel_e;

  localparam reg_sel_e TIM_SEL [NUM_TIM] = '{SEL_TIM0, SEL_TIM1, SEL_TIM2};

  typedef struct packed {
    logic              en;
    logic              mono;
    logic [1:0]        irq_mask;
    logic              tft;
    logic [1:0]        pal_mode;
    logic [DATA_W-1:0] keep;
  } ctrl_t;
endpackage

// File: rtl/lcdc_rst_sync.sv
module lcdc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_reg_pkg::*;
#(
  parameter int unsigned DIM_W = 10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  reg_sel_e                       sel_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output ctrl_t                          ctrl_o,
  output logic [NUM_TIM-1:0][DATA_W-1:0] tim_o,
  output logic [DATA_W-1:0]              sub_o,
  output logic                           en_chg_o,
  output logic [DIM_W:0]                 width_o,
  output logic [DIM_W:0]                 height_o
);
  ctrl_t             ctrl_d, ctrl_q;
  logic              chg_d, chg_q;
  logic [DATA_W-1:0] sub_d, sub_q;
  logic              ctrl_we, sub_we;

  assign ctrl_we = wr_i && (sel_i == SEL_CTRL);
  assign sub_we  = wr_i && (sel_i == SEL_SUB);

  always_comb begin
    ctrl_d = ctrl_q;
    chg_d  = 1'b0;
    if (ctrl_we) begin
      ctrl_d.en       = wdata_i[CB_EN];
      ctrl_d.mono     = wdata_i[CB_MONO];
      ctrl_d.irq_mask = wdata_i[CB_MASK +: 2];
      ctrl_d.tft      = wdata_i[CB_TFT];
      ctrl_d.pal_mode = wdata_i[CB_PLM +: 2];
      ctrl_d.keep     = wdata_i & CTRL_KEEP;
      chg_d           = (wdata_i[CB_EN] != ctrl_q.en);
    end
  end

  always_comb begin
    sub_d = sub_q;
    if (sub_we) sub_d = wdata_i & SUB_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      chg_q  <= 1'b0;
      sub_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      chg_q  <= chg_d;
      sub_q  <= sub_d;
    end
  end

  for (genvar t = 0; t < NUM_TIM; t++) begin : g_tim
    logic              we;
    logic [DATA_W-1:0] d, q;
    assign we = wr_i && (sel_i == TIM_SEL[t]);
    always_comb begin
      d = q;
      if (we) d = wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
    assign tim_o[t] = q;
  end

  assign ctrl_o   = ctrl_q;
  assign sub_o    = sub_q;
  assign en_chg_o = chg_q;
  assign width_o  = {1'b0, tim_o[0][DIM_W-1:0]} + 1'b1;
  assign height_o = {1'b0, tim_o[1][DIM_W-1:0]} + 1'b1;

  AST_EN_CHG_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (ctrl_q.en != $past(ctrl_q.en))); // R8
  AST_EN_NO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en != $past(ctrl_q.en)) |-> chg_q); // R8
endmodule

// File: rtl/lcdc_flags_irq.sv
module lcdc_flags_irq
  import lcdc_reg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FLG-1:0] set_i,
  input  logic [NUM_FLG-1:0] clr_i,
  input  logic [1:0]         mask_i,
  output logic [NUM_FLG-1:0] flags_o,
  output logic               irq_o
);
  logic [NUM_FLG-1:0] flg_d, flg_q;

  for (genvar k = 0; k < NUM_FLG; k++) begin : g_flg
    always_comb begin
      flg_d[k] = flg_q[k];
      if (set_i[k])      flg_d[k] = 1'b1;
      else if (clr_i[k]) flg_d[k] = 1'b0;
    end
    AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flg_q[k]); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(set_i[k] || clr_i[k]) |=> $stable(flg_q[k])); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign flags_o = flg_q;
  assign irq_o   = (flg_q[FLG_FRAME] & mask_i[0]) |
                   (flg_q[FLG_PAL]   & mask_i[1]) |
                    flg_q[FLG_SYNC];

  AST_SYNC_FORCES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_SYNC] |-> irq_o); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[FLG_SYNC] && mask_i == 2'b00) |-> !irq_o); // R7
endmodule

// File: rtl/lcdc_rd_mux.sv
module lcdc_rd_mux
  import lcdc_reg_pkg::*;
(
  input  reg_sel_e                       sel_i,
  input  ctrl_t                          ctrl_i,
  input  logic [NUM_TIM-1:0][DATA_W-1:0] tim_i,
  input  logic [DATA_W-1:0]              sub_i,
  input  logic [NUM_FLG-1:0]             flags_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] ctrl_rd, stat_rd;

  always_comb begin
    ctrl_rd                  = ctrl_i.keep | CTRL_ONES;
    ctrl_rd[CB_EN]           = ctrl_rd[CB_EN]   | ctrl_i.en;
    ctrl_rd[CB_MONO]         = ctrl_rd[CB_MONO] | ctrl_i.mono;
    ctrl_rd[CB_MASK +: 2]    = ctrl_rd[CB_MASK +: 2] | ctrl_i.irq_mask;
    ctrl_rd[CB_TFT]          = ctrl_rd[CB_TFT]  | ctrl_i.tft;
    ctrl_rd[CB_TFT_HI]       = ctrl_rd[CB_TFT_HI] | ctrl_i.tft;
    ctrl_rd[CB_PLM +: 2]     = ctrl_rd[CB_PLM +: 2] | ctrl_i.pal_mode;
  end

  always_comb begin
    stat_rd           = '0;
    stat_rd[SB_FRAME] = flags_i[FLG_FRAME];
    stat_rd[SB_SYNC]  = flags_i[FLG_SYNC];
    stat_rd[SB_PAL]   = flags_i[FLG_PAL];
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = ctrl_rd;
      SEL_TIM0: rdata_o = tim_i[0] | TIM0_ONES;
      SEL_TIM1: rdata_o = tim_i[1];
      SEL_TIM2: rdata_o = tim_i[2] | TIM2_ONES;
      SEL_STAT: rdata_o = stat_rd;
      SEL_SUB:  rdata_o = sub_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lcdc_regblk.sv
module lcdc_regblk
  import lcdc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIM_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [2:0]         flag_set_i,
  input  logic [2:0]         flag_clr_i,
  output logic               irq_o,
  output logic               en_chg_o,
  output logic               lcd_en_o,
  output logic               mono_o,
  output logic               tft_o,
  output logic [1:0]         pal_mode_o,
  output logic [DIM_W:0]     width_o,
  output logic [DIM_W:0]     height_o
);
  logic                           rst_n;
  reg_sel_e                       sel;
  ctrl_t                          ctrl;
  logic [NUM_TIM-1:0][DATA_W-1:0] tim;
  logic [DATA_W-1:0]              sub;
  logic [NUM_FLG-1:0]             flags;

  lcdc_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  always_comb begin
    if      (bus_addr_i == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
    else if (bus_addr_i == ADDR_W'(OFS_TIM0)) sel = SEL_TIM0;
    else if (bus_addr_i == ADDR_W'(OFS_TIM1)) sel = SEL_TIM1;
    else if (bus_addr_i == ADDR_W'(OFS_TIM2)) sel = SEL_TIM2;
    else if (bus_addr_i == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (bus_addr_i == ADDR_W'(OFS_SUB))  sel = SEL_SUB;
    else                                      sel = SEL_NONE;
  end

  lcdc_cfg_regs #(.DIM_W(DIM_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(bus_wr_i), .sel_i(sel),
    .wdata_i(bus_wdata_i), .ctrl_o(ctrl), .tim_o(tim), .sub_o(sub),
    .en_chg_o(en_chg_o), .width_o(width_o), .height_o(height_o)
  );

  lcdc_flags_irq u_flg (
    .clk_i(clk_i), .rst_ni(rst_n), .set_i(flag_set_i), .clr_i(flag_clr_i),
    .mask_i(ctrl.irq_mask), .flags_o(flags), .irq_o(irq_o)
  );

  lcdc_rd_mux u_rd (
    .sel_i(sel), .ctrl_i(ctrl), .tim_i(tim), .sub_i(sub),
    .flags_i(flags), .rdata_o(bus_rdata_o)
  );

  assign lcd_en_o   = ctrl.en;
  assign mono_o     = ctrl.mono;
  assign tft_o      = ctrl.tft;
  assign pal_mode_o = ctrl.pal_mode;

  AST_CTRL_ONES: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel == SEL_CTRL) |-> ((bus_rdata_o & CTRL_ONES) == CTRL_ONES)); // R2
  AST_SUB_MASKED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel == SEL_SUB) |-> ((bus_rdata_o & ~SUB_KEEP) == '0)); // R6
  AST_STAT_ONLY_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel == SEL_STAT) |-> ((bus_rdata_o & ~32'h0000_0045) == '0)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata_o == '0)); // R11
endmodule

// File: tb/lcdc_regblk_tb_top.sv
module lcdc_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  fset = '0, fclr = '0;
  logic        irq, en_chg, lcd_en, mono, tft;
  logic [1:0]  pal_mode;
  logic [10:0] width, height;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcdc_regblk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .flag_set_i(fset),
    .flag_clr_i(fclr), .irq_o(irq), .en_chg_o(en_chg), .lcd_en_o(lcd_en),
    .mono_o(mono), .tft_o(tft), .pal_mode_o(pal_mode),
    .width_o(width), .height_o(height)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rexp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'd2,  8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFBF}, // R2 all ones
    '{8'd2,  8'h00, 32'h0000_0000, 32'hFE00_0C34}, // R2 all zero
    '{8'd2,  8'h00, 32'h0000_0082, 32'hFE80_0CB6}, // R2 tft mirrored
    '{8'd3,  8'h04, 32'h1234_5678, 32'h1234_567F}, // R3 width word
    '{8'd3,  8'h08, 32'hABCD_E3FF, 32'hABCD_E3FF}, // R3 height word
    '{8'd4,  8'h0c, 32'h0000_1234, 32'hFC00_1234}, // R4
    '{8'd6,  8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF}, // R6
    '{8'd5,  8'h10, 32'hFFFF_FFFF, 32'h0000_0000}, // R5 write ignored
    '{8'd11, 8'h20, 32'hFFFF_FFFF, 32'h0000_0000}  // R11 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic flag_pulse(input logic [2:0] s, input logic [2:0] c);
    @(negedge clk);
    fset = s; fclr = c;
    @(negedge clk);
    fset = '0; fclr = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    bus_read(8'h00, rd); check("R10 ctrl", rd, 32'hFE00_0C34);
    bus_read(8'h04, rd); check("R10 tim0", rd, 32'h0000_000F);
    bus_read(8'h08, rd); check("R10 tim1", rd, 32'h0);
    bus_read(8'h0c, rd); check("R10 tim2", rd, 32'hFC00_0000);
    bus_read(8'h10, rd); check("R10 stat", rd, 32'h0);
    bus_read(8'h14, rd); check("R10 sub", rd, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);
    check("R10 pulse", {31'b0, en_chg}, 32'h0);
    check("R10 width", {21'b0, width}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VECS[i].addr, VECS[i].wdata);
      bus_read(VECS[i].addr, rd);
      check($sformatf("R%0d table[%0d]", VECS[i].req, i), rd, VECS[i].rexp);
    end

    // R3 dimension outputs, R11 unmapped writes left registers intact
    check("R3 width", {21'b0, width}, 32'h279);
    check("R3 height", {21'b0, height}, 32'h400);
    bus_write(8'h18, 32'h0);
    bus_read(8'h14, rd); check("R11 sub kept", rd, 32'hA1FF_FFFF);
    bus_read(8'h0c, rd); check("R11 tim2 kept", rd, 32'hFC00_1234);
    bus_read(8'h18, rd); check("R11 read zero", rd, 32'h0);

    // R1 decoded fields: control last written 0x82
    check("R1 fields", {26'b0, lcd_en, mono, tft, pal_mode, 1'b0},
          {26'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0});
    bus_write(8'h00, 32'h0020_0000);
    check("R1 pal_mode", {30'b0, pal_mode}, 32'd2);

    // R7 and R9 flags and interrupt (mask now 0)
    flag_pulse(3'b001, 3'b000);
    bus_read(8'h10, rd); check("R9 frame set", rd, 32'h1);
    check("R7 masked frame", {31'b0, irq}, 32'h0);
    bus_write(8'h00, 32'h0000_0008);
    check("R7 frame irq", {31'b0, irq}, 32'h1);
    flag_pulse(3'b010, 3'b000);
    bus_read(8'h10, rd); check("R9 pal set", rd, 32'h41);
    bus_write(8'h00, 32'h0000_0010);
    check("R7 pal irq", {31'b0, irq}, 32'h1);
    flag_pulse(3'b000, 3'b010);
    check("R7 frame masked by bit1 mask", {31'b0, irq}, 32'h0);
    bus_write(8'h00, 32'h0);
    flag_pulse(3'b100, 3'b001);
    bus_read(8'h10, rd); check("R9 sync set", rd, 32'h4);
    check("R7 sync ignores mask", {31'b0, irq}, 32'h1);
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, rd); check("R5 status write ignored", rd, 32'h4);
    flag_pulse(3'b001, 3'b001);
    bus_read(8'h10, rd); check("R9 set beats clear", rd, 32'h5);
    flag_pulse(3'b000, 3'b111);
    bus_read(8'h10, rd); check("R9 clear all", rd, 32'h0);
    check("R7 idle", {31'b0, irq}, 32'h0);

    // R8 enable change pulse
    bus_write(8'h00, 32'h1);
    check("R8 pulse rises", {30'b0, en_chg, lcd_en}, 32'h3);
    @(negedge clk);
    check("R8 pulse one clock", {30'b0, en_chg, lcd_en}, 32'h1);
    bus_write(8'h00, 32'h1);
    check("R8 no pulse same", {31'b0, en_chg}, 32'h0);
    bus_write(8'h00, 32'h0);
    check("R8 pulse on disable", {30'b0, en_chg, lcd_en}, 32'h2);

    finish_run();
  end
endmodule